// File: doc/BRIEF.md
# Serial Configuration Register File

This block is the write-only control port of a converter front end. A host lowers an active-low select, clocks in a 12-bit frame on a serial clock and data line, and raises the select to commit the frame. The frame carries a 4-bit register address and an 8-bit value, each sent most significant bit first. The block keeps a small sparse map: two registers that together form a 10-bit clamp level, one gain register and one control register. It drives the decoded fields as parallel outputs for the analog side.

The three serial pins are asynchronous to the system clock. Each passes through a two-stage synchroniser, and their edges are detected in the system clock domain. A frame is applied only when the select returns high after exactly twelve sampled bits. Anything else is discarded. A frame sent to an address with no register behind it changes nothing.

Top module: `serial_cfg_regfile`

## Requirements
- R1: After reset the clamp level is 0, the gain select is 3'b001 (unity gain), and every other output is 0.
- R2: While the select is low, one data bit is sampled on each serial clock rising edge. The first 4 bits form the address, MSB first. The next 8 bits form the value, MSB first.
- R3: Outputs change only when the select rises. Twelve clocked bits with the select still low leave every output as it was.
- R4: Address 0 writes clamp level bits 7:0. Address 1 writes clamp level bits 9:8 from value bits 1:0, and its upper value bits are ignored.
- R5: Address 2 sets the gain select from bits 2:0, the offset enable from bit 4 and the offset polarity from bit 5.
- R6: Address 3 sets power-down from bit 0, clamp disable from bit 1, two's complement from bit 2, output disable from bit 3 and clamp source from bit 4.
- R7: A frame addressed to 4 through 15 changes no output.
- R8: A frame with fewer or more than 12 sampled bits when the select rises is discarded.
- R9: A committed value appears on the outputs at the third system clock rising edge after the select rises at the pin.
- R10: Serial clock edges while the select is high are ignored. The bit count and shift register restart when the select falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n_i | input | 1 | Frame select, active low; its rising edge commits |
| sclk_i | input | 1 | Serial clock |
| sdata_i | input | 1 | Serial data |
| clamp_level_o | output | 10 | Clamp DAC level |
| gain_sel_o | output | 3 | Gain select code |
| offset_en_o | output | 1 | Coarse offset enable |
| offset_neg_o | output | 1 | Coarse offset polarity |
| powerdown_o | output | 1 | Power-down request |
| clamp_off_o | output | 1 | Clamp amplifier disable |
| twos_comp_o | output | 1 | Two's complement output format |
| out_disable_o | output | 1 | Output data disable |
| clamp_src_o | output | 1 | Clamp source select |

## Verification
Every result depends on the rising edge of the select at the pin. The signal passes through two synchroniser flops, and the map register is written on the next edge. A committed value is therefore due at the third system clock rising edge after the select rises. The bench drives every serial pin on the falling clock edge and holds each level for four system clocks. It samples outputs on falling edges. Table vectors are checked several cycles after the commit. The latency test samples after the second and then after the third rising edge, showing the old value first and the new value second.

// File: rtl/serial_cfg_pkg.sv
package serial_cfg_pkg;
  localparam int ADDR_W  = 4;
  localparam int DATA_W  = 8;
  localparam int FRAME_W = ADDR_W + DATA_W;
  localparam int CNT_W   = $clog2(FRAME_W + 2);
  localparam int DAC_W   = 10;
  localparam int GAIN_W  = 3;
  localparam int SYNC_STAGES = 2;

  localparam logic [ADDR_W-1:0] A_DAC_LO = 4'd0;
  localparam logic [ADDR_W-1:0] A_DAC_HI = 4'd1;
  localparam logic [ADDR_W-1:0] A_GAIN   = 4'd2;
  localparam logic [ADDR_W-1:0] A_CTRL   = 4'd3;

  localparam logic [GAIN_W-1:0] GAIN_RST = 3'b001;

  typedef struct packed {
    logic [DAC_W-1:0]  dac;
    logic [GAIN_W-1:0] gain;
    logic              off_en;
    logic              off_neg;
    logic              pd;
    logic              cl_off;
    logic              twos;
    logic              out_dis;
    logic              cl_src;
  } cfg_t;
endpackage

// File: rtl/serial_cfg_sync.sv
module serial_cfg_sync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[s] <= RST_VAL;
        else if (s == 0) stage_q[s] <= d_i;
        else stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/serial_cfg_shifter.sv
module serial_cfg_shifter
  import serial_cfg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n_s,
  input  logic              sclk_s,
  input  logic              sdata_s,
  output logic              commit_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] data_o
);
  logic               cs_prev_q, sclk_prev_q;
  logic [FRAME_W-1:0] sh_q, sh_d;
  logic [CNT_W-1:0]   cnt_q, cnt_d;
  logic               cs_fall, cs_rise, sclk_rise;

  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_W);
  localparam logic [CNT_W-1:0] CNT_SAT  = CNT_W'(FRAME_W + 1);

  assign cs_fall   = cs_prev_q & ~cs_n_s;
  assign cs_rise   = ~cs_prev_q & cs_n_s;
  assign sclk_rise = ~sclk_prev_q & sclk_s;

  always_comb begin
    sh_d  = sh_q;
    cnt_d = cnt_q;
    if (cs_fall) begin
      sh_d  = '0;
      cnt_d = '0;
    end else if (sclk_rise && !cs_n_s) begin
      sh_d = {sh_q[FRAME_W-2:0], sdata_s};
      if (cnt_q != CNT_SAT) cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_prev_q   <= 1'b1;
      sclk_prev_q <= 1'b0;
      sh_q        <= '0;
      cnt_q       <= '0;
    end else begin
      cs_prev_q   <= cs_n_s;
      sclk_prev_q <= sclk_s;
      sh_q        <= sh_d;
      cnt_q       <= cnt_d;
    end
  end

  assign commit_o = cs_rise && (cnt_q == CNT_FULL);
  assign addr_o   = sh_q[FRAME_W-1:DATA_W];
  assign data_o   = sh_q[DATA_W-1:0];
endmodule

// File: rtl/serial_cfg_map.sv
module serial_cfg_map
  import serial_cfg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              commit_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  output cfg_t              cfg_o
);
  cfg_t cfg_q, cfg_d;

  always_comb begin
    cfg_d = cfg_q;
    if (commit_i) begin
      unique case (addr_i)
        A_DAC_LO: cfg_d.dac[7:0] = data_i;
        A_DAC_HI: cfg_d.dac[DAC_W-1:8] = data_i[DAC_W-9:0];
        A_GAIN: begin
          cfg_d.gain    = data_i[GAIN_W-1:0];
          cfg_d.off_en  = data_i[4];
          cfg_d.off_neg = data_i[5];
        end
        A_CTRL: begin
          cfg_d.pd      = data_i[0];
          cfg_d.cl_off  = data_i[1];
          cfg_d.twos    = data_i[2];
          cfg_d.out_dis = data_i[3];
          cfg_d.cl_src  = data_i[4];
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q      <= '0;
      cfg_q.gain <= GAIN_RST;
    end else if (commit_i) begin
      cfg_q <= cfg_d;
    end
  end

  assign cfg_o = cfg_q;
endmodule

// File: rtl/serial_cfg_regfile.sv
module serial_cfg_regfile
  import serial_cfg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n_i,
  input  logic              sclk_i,
  input  logic              sdata_i,
  output logic [DAC_W-1:0]  clamp_level_o,
  output logic [GAIN_W-1:0] gain_sel_o,
  output logic              offset_en_o,
  output logic              offset_neg_o,
  output logic              powerdown_o,
  output logic              clamp_off_o,
  output logic              twos_comp_o,
  output logic              out_disable_o,
  output logic              clamp_src_o
);
  logic              rst_meta_q, rst_sync_n;
  logic [2:0]        pins_s;
  logic              commit_w;
  logic [ADDR_W-1:0] frm_addr;
  logic [DATA_W-1:0] frm_data;
  cfg_t              cfg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  serial_cfg_sync #(
    .WIDTH  (3),
    .STAGES (SYNC_STAGES),
    .RST_VAL(3'b100)
  ) u_sync (
    .clk  (clk),
    .rst_n(rst_sync_n),
    .d_i  ({cs_n_i, sclk_i, sdata_i}),
    .q_o  (pins_s)
  );

  serial_cfg_shifter u_shift (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .cs_n_s  (pins_s[2]),
    .sclk_s  (pins_s[1]),
    .sdata_s (pins_s[0]),
    .commit_o(commit_w),
    .addr_o  (frm_addr),
    .data_o  (frm_data)
  );

  serial_cfg_map u_map (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .commit_i(commit_w),
    .addr_i  (frm_addr),
    .data_i  (frm_data),
    .cfg_o   (cfg)
  );

  assign clamp_level_o = cfg.dac;
  assign gain_sel_o    = cfg.gain;
  assign offset_en_o   = cfg.off_en;
  assign offset_neg_o  = cfg.off_neg;
  assign powerdown_o   = cfg.pd;
  assign clamp_off_o   = cfg.cl_off;
  assign twos_comp_o   = cfg.twos;
  assign out_disable_o = cfg.out_dis;
  assign clamp_src_o   = cfg.cl_src;
endmodule

// File: rtl/serial_cfg_regfile_chk.sv
module serial_cfg_regfile_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       commit,
  input logic [3:0] addr,
  input logic [7:0] data,
  input logic [9:0] clamp,
  input logic [2:0] gain,
  input logic       off_en,
  input logic       off_neg,
  input logic       pd,
  input logic       cl_off,
  input logic       twos,
  input logic       out_dis,
  input logic       cl_src
);
  logic [19:0] outs;
  assign outs = {clamp, gain, off_en, off_neg, pd, cl_off, twos, out_dis, cl_src};

  assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !commit |=> $stable(outs));

  assert_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> !commit);

  assert_lo_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && addr == 4'd0) |=> (clamp[7:0] == $past(data)));

  assert_gain_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && addr == 4'd2) |=> (gain == $past(data[2:0]) && off_en == $past(data[4])
                                  && off_neg == $past(data[5])));

  assert_ctrl_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && addr == 4'd3) |=> ({cl_src, out_dis, twos, cl_off, pd} == $past(data[4:0])));

  assert_reserved_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && addr >= 4'd4) |=> $stable(outs));
endmodule

bind serial_cfg_regfile serial_cfg_regfile_chk u_chk (
  .clk    (clk),
  .rst_n  (rst_sync_n),
  .commit (commit_w),
  .addr   (frm_addr),
  .data   (frm_data),
  .clamp  (clamp_level_o),
  .gain   (gain_sel_o),
  .off_en (offset_en_o),
  .off_neg(offset_neg_o),
  .pd     (powerdown_o),
  .cl_off (clamp_off_o),
  .twos   (twos_comp_o),
  .out_dis(out_disable_o),
  .cl_src (clamp_src_o)
);

// File: tb/serial_cfg_regfile_bench.sv
module serial_cfg_regfile_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1, sclk = 1'b0, sdata = 1'b0;
  logic [9:0] clamp_level;
  logic [2:0] gain_sel;
  logic offset_en, offset_neg, powerdown, clamp_off, twos_comp, out_disable, clamp_src;

  int checks = 0;
  int errors = 0;

  logic [9:0] m_clamp = 10'd0;
  logic [2:0] m_gain  = 3'b001;
  logic       m_en = 1'b0, m_neg = 1'b0;
  logic [4:0] m_ctrl  = 5'd0;

  always #5 clk = ~clk;

  serial_cfg_regfile u_serial_cfg_regfile (
    .clk(clk), .rst_n(rst_n), .cs_n_i(cs_n), .sclk_i(sclk), .sdata_i(sdata),
    .clamp_level_o(clamp_level), .gain_sel_o(gain_sel), .offset_en_o(offset_en),
    .offset_neg_o(offset_neg), .powerdown_o(powerdown), .clamp_off_o(clamp_off),
    .twos_comp_o(twos_comp), .out_disable_o(out_disable), .clamp_src_o(clamp_src)
  );

  // {addr, value, bits sent}
  localparam int NV = 11;
  localparam logic [16:0] VEC [NV] = '{
    {4'h0, 8'hA5, 5'd12},
    {4'h1, 8'hFE, 5'd12},
    {4'h2, 8'h37, 5'd12},
    {4'h3, 8'h1F, 5'd12},
    {4'h3, 8'h0A, 5'd12},
    {4'h4, 8'hFF, 5'd12},
    {4'hF, 8'h00, 5'd12},
    {4'h2, 8'h00, 5'd11},
    {4'h2, 8'h00, 5'd13},
    {4'h2, 8'hC2, 5'd12},
    {4'h0, 8'h00, 5'd12}
  };

  function automatic logic [19:0] actual();
    return {clamp_level, gain_sel, offset_en, offset_neg,
            clamp_src, out_disable, twos_comp, clamp_off, powerdown};
  endfunction

  function automatic logic [19:0] expected();
    return {m_clamp, m_gain, m_en, m_neg, m_ctrl};
  endfunction

  task automatic model_apply(input logic [3:0] a, input logic [7:0] d, input int n);
    if (n != 12) return;
    case (a)
      4'h0: m_clamp[7:0] = d;
      4'h1: m_clamp[9:8] = d[1:0];
      4'h2: begin m_gain = d[2:0]; m_en = d[4]; m_neg = d[5]; end
      4'h3: m_ctrl = d[4:0];
      default: ;
    endcase
  endtask

  task automatic check(input string tag, input logic [19:0] act, input logic [19:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic send_bits(input logic [3:0] a, input logic [7:0] d, input int n);
    logic [11:0] fr;
    fr = {a, d};
    @(negedge clk);
    cs_n = 1'b0;
    wait_clk(4);
    for (int i = 0; i < n; i++) begin
      sdata = (i < 12) ? fr[11-i] : 1'b1;
      wait_clk(4);
      sclk = 1'b1;
      wait_clk(4);
      sclk = 1'b0;
    end
    wait_clk(4);
  endtask

  task automatic raise_cs();
    cs_n = 1'b1;
    wait_clk(8);
  endtask

  initial begin
    #1_000_000;
    errors++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    wait_clk(3);
    rst_n = 1'b1;
    wait_clk(4);
    check("R1 reset values", actual(), expected());

    // table walk: R2 R4 R5 R6 R7 R8
    for (int v = 0; v < NV; v++) begin
      logic [3:0] a;
      logic [7:0] d;
      int n;
      a = VEC[v][16:13];
      d = VEC[v][12:5];
      n = int'(VEC[v][4:0]);
      send_bits(a, d, n);
      raise_cs();
      model_apply(a, d, n);
      check($sformatf("R2/R4/R5/R6/R7/R8 vector %0d", v), actual(), expected());
    end

    // R3: full frame with select low changes nothing
    send_bits(4'h3, 8'h01, 12);
    check("R3 no update before select rise", actual(), expected());

    // R9: latency of three rising edges
    cs_n = 1'b1;
    @(posedge clk); @(posedge clk); @(negedge clk);
    check("R9 still old after two edges", actual(), expected());
    model_apply(4'h3, 8'h01, 12);
    @(posedge clk); @(negedge clk);
    check("R9 new value at third edge", actual(), expected());
    wait_clk(6);

    // R10: serial clock while select high is ignored
    sdata = 1'b1;
    for (int i = 0; i < 5; i++) begin
      wait_clk(4); sclk = 1'b1; wait_clk(4); sclk = 1'b0;
    end
    send_bits(4'h0, 8'h3C, 12);
    raise_cs();
    model_apply(4'h0, 8'h3C, 12);
    check("R10 idle clocks ignored", actual(), expected());

    // R10: aborted short frame, then a clean frame restarts the count
    send_bits(4'h1, 8'h03, 7);
    raise_cs();
    check("R8 aborted frame discarded", actual(), expected());
    send_bits(4'h1, 8'h03, 12);
    raise_cs();
    model_apply(4'h1, 8'h03, 12);
    check("R10 restart after abort, R4 high bits", actual(), expected());

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule